// File: doc/BRIEF.md
# Serial Read-Frame Host Controller

This block is the host side of a 32-clock serial read frame. A one-cycle start request with a 6-bit register address opens a transaction. The controller raises a frame enable and drives the read flag, and then toggles a serial clock made from the system clock by a half-period divider. It shifts the address out MSB first and collects 24 returned data bits MSB first from a shared return pin. It closes the frame and reports the word with a one-cycle done pulse.

The same return pin carries a lock-status level whenever no frame is in progress. The controller copies it into a lock output only while its enable output is low, and it keeps the last value for the whole frame. Enable-to-clock setup and the enable-low gap between frames are given in nanoseconds. They are rounded up to whole system-clock counts.

Top module: `serial_rd_master`

## Requirements
- R1: After reset, sen_o, sclk_o, sdo_o, busy_o and done_o are all 0.
- R2: A start_i pulse taken while busy_o is 0 raises sen_o and sdo_o (read flag = 1) together. sclk_o stays low for at least ceil(SETUP_NS/CLK_NS) system cycles after that, before its first rising edge.
- R3: A frame has exactly 32 sclk_o rising edges spaced 2*HALF_DIV system cycles apart, and sclk_o is 0 whenever sen_o is 0.
- R4: At rising edge 1 sdo_o is 1. At rising edges 2 to 7 it carries addr bits 5 down to 0. sdo_o changes only on falling edges, so its value is stable across every rising edge.
- R5: The controller samples sdi_i on falling edges 8 to 31. The first bit sampled becomes rdata_o[23] and the last becomes rdata_o[0].
- R6: sen_o and sclk_o drop on falling edge 32. In the next cycle done_o is high for exactly one cycle with rdata_o valid.
- R7: busy_o stays high through a gap after the frame. Between two frames sen_o stays low for at least ceil(LOW_NS/CLK_NS) system cycles.
- R8: A start_i pulse while busy_o is 1 is ignored: the current address is unchanged and no extra frame follows. This includes a start pulse in the same cycle as done_o.
- R9: lock_o copies sdi_i (one-cycle register) only while sen_o is low. While sen_o is high, lock_o holds its value.
- R10: sdo_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle read request |
| addr_i | input | 6 | Register address for the request |
| sdi_i | input | 1 | Shared return pin: data during a frame, lock level otherwise |
| busy_o | output | 1 | Frame or post-frame gap in progress |
| done_o | output | 1 | One-cycle pulse, rdata_o valid |
| rdata_o | output | 24 | Returned data word |
| lock_o | output | 1 | Lock status captured while enable is low |
| sen_o | output | 1 | Frame enable |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data to the target |

## Verification
Two events can share a cycle here. The first is the done pulse and a fresh start request, which the controller must refuse because it is still in its enable-low gap. The bench drives start_i in exactly the cycle where it sees done_o, with a different address. It then requires sen_o to stay low and no second frame to appear. The second is the enable rise and a change on the shared pin. The bench flips the lock level right after enable goes high and checks that lock_o keeps its pre-frame value on every cycle of the frame. It takes the new level only after enable falls.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_FRAME = 2'd2,
    ST_GAP   = 2'd3
  } srm_state_e;

  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 24;
  localparam int EDGE_W  = 6;
  localparam int LAST_ADDR_EDGE = 1 + ADDR_W;      // edge 7: address done
  localparam int FIRST_DATA_EDGE = LAST_ADDR_EDGE + 1;
  localparam int LAST_DATA_EDGE = FIRST_DATA_EDGE + DATA_W - 1;
  localparam int FRAME_EDGES = LAST_DATA_EDGE + 1; // 32
endpackage

// File: rtl/srm_halfclk.sv
module srm_halfclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int HC_W = $clog2(HALF_DIV + 1);

  logic [HC_W-1:0] hcnt_q, hcnt_d;
  logic            wrap;

  assign wrap   = (hcnt_q == HC_W'(HALF_DIV - 1));
  assign tick_o = run_i && wrap;

  always_comb begin
    hcnt_d = hcnt_q;
    if (!run_i)    hcnt_d = '0;
    else if (wrap) hcnt_d = '0;
    else           hcnt_d = hcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= '0;
    else        hcnt_q <= hcnt_d;
  end

  generate
    if (HALF_DIV > 1) begin : g_spaced
      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/srm_shifter.sv
module srm_shifter
  import srm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tx_shift_i,
  input  logic              rx_cap_i,
  input  logic              sdi_i,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [ADDR_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i)          tx_d = addr_i;
    else if (tx_shift_i) tx_d = {tx_q[ADDR_W-2:0], 1'b0};
    rx_d = rx_q;
    if (rx_cap_i)        rx_d = {rx_q[DATA_W-2:0], sdi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_bit_o = tx_q[ADDR_W-1];
  assign rx_o     = rx_q;

  // R4
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && tx_shift_i));
endmodule

// File: rtl/srm_lock.sv
module srm_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic sen_i,
  input  logic sdi_i,
  output logic lock_o
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= 1'b0;
    else if (!sen_i) lock_q <= sdi_i;
  end

  assign lock_o = lock_q;

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sen_i) |-> $stable(lock_o));
endmodule

// File: rtl/serial_rd_master.sv
module serial_rd_master
  import srm_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int HALF_DIV = 2,
  parameter int SETUP_NS = 8,
  parameter int LOW_NS   = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [5:0]  addr_i,
  input  logic        sdi_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [23:0] rdata_o,
  output logic        lock_o,
  output logic        sen_o,
  output logic        sclk_o,
  output logic        sdo_o
);
  localparam int SETUP_RAW = (SETUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int LOW_RAW   = (LOW_NS + CLK_NS - 1) / CLK_NS;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int LOW_CYC   = (LOW_RAW < 1) ? 1 : LOW_RAW;
  localparam int WMAX      = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
  localparam int WCNT_W    = $clog2(WMAX + 1);

  srm_state_e         state_q, state_d;
  logic [WCNT_W-1:0]  wcnt_q, wcnt_d;
  logic [EDGE_W-1:0]  edge_q, edge_d;
  logic               sclk_q, sclk_d, sen_q, sen_d, sdo_q, sdo_d, done_q, done_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d, rx_word;
  logic               tick, rise, fall, load, tx_shift, rx_cap, tx_bit;

  srm_halfclk #(.HALF_DIV(HALF_DIV)) u_halfclk (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_FRAME), .tick_o(tick));

  srm_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .load_i(load), .addr_i(addr_i),
    .tx_shift_i(tx_shift), .rx_cap_i(rx_cap), .sdi_i(sdi_i),
    .tx_bit_o(tx_bit), .rx_o(rx_word));

  srm_lock u_lock (
    .clk(clk), .rst_n(rst_n), .sen_i(sen_q), .sdi_i(sdi_i), .lock_o(lock_o));

  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;

  always_comb begin
    state_d  = state_q;
    wcnt_d   = wcnt_q;
    edge_d   = edge_q;
    sclk_d   = sclk_q;
    sen_d    = sen_q;
    sdo_d    = sdo_q;
    rdata_d  = rdata_q;
    done_d   = 1'b0;
    load     = 1'b0;
    tx_shift = 1'b0;
    rx_cap   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SETUP;
        sen_d   = 1'b1;
        sdo_d   = 1'b1;
        wcnt_d  = '0;
        load    = 1'b1;
      end
      ST_SETUP: begin
        if (wcnt_q == WCNT_W'(SETUP_CYC - 1)) begin
          state_d = ST_FRAME;
          sclk_d  = 1'b1;
          edge_d  = EDGE_W'(1);
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_FRAME: begin
        if (rise) begin
          sclk_d = 1'b1;
          edge_d = edge_q + 1'b1;
        end else if (fall) begin
          sclk_d = 1'b0;
          if (edge_q < EDGE_W'(LAST_ADDR_EDGE)) begin
            sdo_d    = tx_bit;
            tx_shift = 1'b1;
          end else if (edge_q == EDGE_W'(LAST_ADDR_EDGE)) begin
            sdo_d = 1'b0;
          end
          if (edge_q >= EDGE_W'(FIRST_DATA_EDGE) && edge_q <= EDGE_W'(LAST_DATA_EDGE))
            rx_cap = 1'b1;
          if (edge_q == EDGE_W'(FRAME_EDGES)) begin
            state_d = ST_GAP;
            sen_d   = 1'b0;
            sdo_d   = 1'b0;
            done_d  = 1'b1;
            rdata_d = rx_word;
            wcnt_d  = '0;
          end
        end
      end
      ST_GAP: begin
        if (wcnt_q == WCNT_W'(LOW_CYC - 1)) state_d = ST_IDLE;
        else                                wcnt_d  = wcnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      edge_q  <= '0;
      sclk_q  <= 1'b0;
      sen_q   <= 1'b0;
      sdo_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      edge_q  <= edge_d;
      sclk_q  <= sclk_d;
      sen_q   <= sen_d;
      sdo_q   <= sdo_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign sen_o   = sen_q;
  assign sclk_o  = sclk_q;
  assign sdo_o   = sdo_q;

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_o |-> !sclk_o);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(sen_o));
  // R8
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sen_o) |-> $past(start_i && !busy_o));
  // R10
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sdo_o);
  // R7
  gap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sen_o) |-> busy_o);
endmodule

// File: tb/serial_rd_master_bench.sv
module serial_rd_master_bench;
  localparam int CLK_NS = 10, HALF_DIV = 2, SETUP_NS = 8, LOW_NS = 20;
  localparam int SETUP_CYC = (SETUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int LOW_CYC   = (LOW_NS + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdi = 1'b0;
  logic [5:0] addr = '0;
  logic busy, done, lock, sen, sclk, sdo;
  logic [23:0] rdata;

  always #5 clk = ~clk;

  serial_rd_master #(.CLK_NS(CLK_NS), .HALF_DIV(HALF_DIV), .SETUP_NS(SETUP_NS),
                     .LOW_NS(LOW_NS)) u_serial_rd_master (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .sdi_i(sdi),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .lock_o(lock),
    .sen_o(sen), .sclk_o(sclk), .sdo_o(sdo));

  int nchk = 0, nfail = 0, cyc = 0;
  // target model state
  logic [23:0] tgt_data = '0;
  logic lock_val = 1'b0, prev_sclk = 1'b0, prev_sen = 1'b0, prev_sdo = 1'b0;
  logic rd_flag = 1'b0, have_frame = 1'b0, hold_err = 1'b0, per_err = 1'b0;
  logic [5:0] addr_rx = '0;
  int rise_n = 0, setup_cnt = 0, gap_cnt = 0, last_gap = 0, since_rise = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (sen && !prev_sen) begin
      setup_cnt = 0; hold_err = 1'b0; per_err = 1'b0;
      if (have_frame) last_gap = gap_cnt;
      gap_cnt = 0;
    end
    if (!sen) begin
      gap_cnt++;
      rise_n = 0;
      sdi = lock_val;
      if (prev_sen) have_frame = 1'b1;
    end else begin
      since_rise++;
      if (rise_n == 0 && !sclk) setup_cnt++;
      if (sclk && !prev_sclk) begin
        rise_n++;
        if (sdo !== prev_sdo) hold_err = 1'b1;
        if (rise_n > 1 && since_rise != 2 * HALF_DIV) per_err = 1'b1;
        since_rise = 0;
        if (rise_n == 1) rd_flag = sdo;
        else if (rise_n <= 7) addr_rx = {addr_rx[4:0], sdo};
        if (rise_n >= 8 && rise_n <= 31) sdi = tgt_data[31 - rise_n];
        else if (rise_n == 32) sdi = lock_val;
      end
    end
    prev_sclk = sclk; prev_sen = sen; prev_sdo = sdo;
  end

  task automatic pulse_start(input logic [5:0] a);
    @(negedge clk); addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    chk(ok, "R6 done timeout", int'(ok), 1);
  endtask

  task automatic check_frame(input logic [5:0] a, input logic [23:0] d);
    chk(rdata == d, "R5 rdata", int'(rdata), int'(d));
    chk(rise_n == 32, "R3 rising count", rise_n, 32);
    chk(!per_err, "R3 sclk period", int'(per_err), 0);
    chk(rd_flag == 1'b1, "R4 read flag", int'(rd_flag), 1);
    chk(addr_rx == a, "R4 address", int'(addr_rx), int'(a));
    chk(!hold_err, "R4 sdo stable at rise", int'(hold_err), 0);
    chk(setup_cnt >= SETUP_CYC, "R2 setup cycles", setup_cnt, SETUP_CYC);
    chk(!sen && !sclk, "R6 frame closed", int'({sen, sclk}), 0);
    @(negedge clk);
    chk(!done, "R6 done one cycle", int'(done), 0);
    chk(busy, "R7 busy in gap", int'(busy), 1);
  endtask

  task automatic t_reset();
    chk({sen, sclk, sdo, busy, done} == 5'b0, "R1 reset outputs",
        int'({sen, sclk, sdo, busy, done}), 0);
    chk(!sdo, "R10 sdo idle", int'(sdo), 0);
  endtask

  task automatic t_read(input logic [5:0] a, input logic [23:0] d);
    logic ok;
    tgt_data = d;
    pulse_start(a);
    chk(sen && sdo && !sclk, "R2 enable and flag", int'({sen, sdo, sclk}), 6);
    wait_done(ok);
    if (ok) check_frame(a, d);
  endtask

  task automatic t_back_to_back();
    logic ok;
    tgt_data = 24'h5A5A5A;
    pulse_start(6'h15);
    wait_done(ok);
    while (busy) @(negedge clk);
    chk(!sdo, "R10 sdo low when idle", int'(sdo), 0);
    addr = 6'h2A; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(last_gap >= LOW_CYC, "R7 enable-low gap", last_gap, LOW_CYC);
    wait_done(ok);
    if (ok) check_frame(6'h2A, 24'h5A5A5A);
  endtask

  task automatic t_busy_start();
    logic ok;
    int extra = 0;
    tgt_data = 24'hC3F00F;
    pulse_start(6'h0F);
    repeat (40) @(negedge clk);
    addr = 6'h30; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(ok);
    if (ok) check_frame(6'h0F, 24'hC3F00F);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sen) extra++;
    end
    chk(extra == 0, "R8 start while busy", extra, 0);
  endtask

  task automatic t_coincide();
    logic ok;
    int extra = 0;
    tgt_data = 24'h00FF01;
    pulse_start(6'h01);
    wait_done(ok);
    addr = 6'h3E; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sen) extra++;
    end
    chk(extra == 0, "R8 start with done", extra, 0);
    chk(!busy, "R7 busy ends after gap", int'(busy), 0);
  endtask

  task automatic t_lock();
    logic ok;
    int moved = 0;
    lock_val = 1'b1;
    repeat (4) @(negedge clk);
    chk(lock == 1'b1, "R9 lock tracks idle pin", int'(lock), 1);
    tgt_data = 24'h000000;
    pulse_start(6'h22);
    lock_val = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (sen && lock !== 1'b1) moved++;
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk(ok && moved == 0, "R9 lock held in frame", moved, 0);
    repeat (4) @(negedge clk);
    chk(lock == 1'b0, "R9 lock follows after frame", int'(lock), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(6'h2D, 24'hA5C3E1);
    t_read(6'h00, 24'hFFFFFF);
    t_read(6'h3F, 24'h800001);
    t_back_to_back();
    t_busy_start();
    t_coincide();
    t_lock();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule